// File: doc/BRIEF.md
# Send DMA abort and restart sequencer

This block is the control sequencer that brings a send DMA engine back into service after it has been aborted. When an abort is requested it holds a disarmed phase, waiting for the engine to report that it has disabled itself. It then polls the engine's status until the engine is quiet. When that is done it issues a single cleanup command: flush the outstanding request tracking, zero the ring pointers and the generation, and rewrite the ring length word with generation checking enabled. The engine enable is dropped at the same point.

Two fallbacks keep the sequencer moving. A disabled indication that never arrives is covered by a deadline. A status that never settles is covered by a bounded retry budget, after which cleanup happens anyway. The engine is restarted straight after cleanup only if the link is active. Otherwise the sequencer parks until a later link-up event. A restart always drives the enable low for one cycle and then high, because the engine starts on a rising edge of enable. Out of reset the sequencer sits in the parked, aborted condition, so the first start is handled the same way as a recovery after a link flap.

Top module: `abort_restart_seq`

## Requirements
- R1: During and right after reset, `state_o` is 2 (aborted) and `eng_en_o`, `cleanup_o`, `lengen_we_o`, `irq_lost_o` and `dbg_o` are all 0.
- R2: An `abort_req_i` seen while running (`state_o`=0 with the enable high) moves the sequencer to disarmed (`state_o`=1) in the next cycle. `eng_en_o` stays 1 while disarmed and polling. An abort request in the parked condition has no effect.
- R3: While disarmed, `disabled_irq_i` ends the phase at the next edge. If the indication is not seen within DISARM_CYCLES cycles, the phase ends after exactly DISARM_CYCLES cycles and `irq_lost_o` is set. An indication in the last cycle wins, and `irq_lost_o` then stays 0.
- R4: The engine counts as quiet only when `drain_busy_i`, `abort_busy_i` and `int_en_i` are all 0 and `sb_empty_i` is 1.
- R5: The polling phase (`state_o`=2 without cleanup) lasts min(q, RETRY_BUDGET)+1 cycles, where q is the index of the first cycle with a quiet engine.
- R6: Cleanup is a single cycle with `cleanup_o`=1 and `lengen_we_o`=1. In that cycle `lengen_data_o` equals ENTRIES with bit GEN_CHK_BIT (18) also set, and `eng_en_o` is 0.
- R7: After cleanup the sequencer restarts at once if `link_active_i` and `running_i` are high. Otherwise it parks (`state_o`=2, enable 0) until `link_evt_i`.
- R8: A restart happens only with `running_i`=1 and `shutdown_i`=0. It spends one cycle with `state_o`=0 and the enable low, then raises `eng_en_o`. An accepted restart clears `irq_lost_o`.
- R9: While `shutdown_i` is high, the sequencer parks in the next cycle with the enable low and no cleanup, and it ignores link events.
- R10: While disarmed or polling, `dbg_o` pulses on every DBG_INTERVAL-th consecutive cycle spent in the same phase. The count restarts whenever the phase changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| abort_req_i | input | 1 | Request to start an abort |
| disabled_irq_i | input | 1 | Engine reports that it is disabled |
| drain_busy_i | input | 1 | Scoreboard drain in progress |
| abort_busy_i | input | 1 | Engine abort in progress |
| int_en_i | input | 1 | Engine internal enable still set |
| sb_empty_i | input | 1 | Scoreboard empty |
| link_active_i | input | 1 | Link is active (level) |
| link_evt_i | input | 1 | Link became active (pulse), restart request |
| running_i | input | 1 | Engine set up and in service |
| shutdown_i | input | 1 | Engine being torn down |
| state_o | output | 2 | Abort status: 0 none, 1 disarmed, 2 aborted |
| eng_en_o | output | 1 | Engine enable command |
| cleanup_o | output | 1 | Flush requests and reset ring pointers and generation |
| lengen_we_o | output | 1 | Write strobe for the length/generation word |
| lengen_data_o | output | LG_W | Length/generation word |
| irq_lost_o | output | 1 | Disarm phase ended by the deadline |
| dbg_o | output | 1 | Paced stall strobe |

## Verification
The disabled indication can arrive in the same cycle that the disarm deadline expires. The bench forces this collision with a directed trial whose indication lands in the last allowed cycle, and it also reaches the collision through the random trials. The result is judged by the length of the disarmed phase and by `irq_lost_o`, which must stay clear. The second overlap is a quiet status that first appears in the cycle the retry budget runs out (q equal to RETRY_BUDGET). Here the bench checks that cleanup comes exactly one cycle later and that it happens only once.

// File: rtl/abort_seq_pkg.sv
`timescale 1ns/1ps
package abort_seq_pkg;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_DISARM = 3'd1,
      S_POLL   = 3'd2,
      S_CLEAN  = 3'd3,
      S_PARK   = 3'd4,
      S_REST0  = 3'd5,
      S_REST1  = 3'd6
   } seq_state_e;

   typedef enum logic [1:0] {
      AST_NONE     = 2'd0,
      AST_DISARMED = 2'd1,
      AST_ABORTED  = 2'd2
   } abort_stat_e;

   function automatic logic engine_quiet(input logic drain_busy, input logic abort_busy,
                                         input logic int_en, input logic sb_empty);
      return !drain_busy && !abort_busy && !int_en && sb_empty;
   endfunction

   function automatic abort_stat_e status_of(input seq_state_e s);
      case (s)
         S_IDLE, S_REST0, S_REST1: return AST_NONE;
         S_DISARM:                 return AST_DISARMED;
         default:                  return AST_ABORTED;
      endcase
   endfunction

endpackage

// File: rtl/seq_countdown.sv
`timescale 1ns/1ps
module seq_countdown #(
   parameter int W = 4
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         dec_i,
   output logic         zero_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    cnt_q <= '0;
      else if (load_i)                cnt_q <= load_val_i;
      else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // R5: a drained counter stays drained until it is reloaded
   a_r5_floor_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/seq_pacer.sv
`timescale 1ns/1ps
module seq_pacer #(
   parameter int PERIOD = 4,
   parameter int W      = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic en_i,
   output logic fire_o
);
   logic [W-1:0] cnt_q;

   assign fire_o = en_i && (cnt_q == W'(PERIOD - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (en_i)   cnt_q <= fire_o ? '0 : cnt_q + 1'b1;
   end

   // R10: pulses are spaced by at least one quiet cycle
   a_r10_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o |=> !fire_o);
endmodule

// File: rtl/abort_restart_seq.sv
`timescale 1ns/1ps
module abort_restart_seq
   import abort_seq_pkg::*;
#(
   parameter int ENTRIES       = 256,
   parameter int LG_W          = 32,
   parameter int GEN_CHK_BIT   = 18,
   parameter int DISARM_CYCLES = 1000,
   parameter int RETRY_BUDGET  = 64,
   parameter int DBG_INTERVAL  = 5000
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            abort_req_i,
   input  logic            disabled_irq_i,
   input  logic            drain_busy_i,
   input  logic            abort_busy_i,
   input  logic            int_en_i,
   input  logic            sb_empty_i,
   input  logic            link_active_i,
   input  logic            link_evt_i,
   input  logic            running_i,
   input  logic            shutdown_i,
   output logic [1:0]      state_o,
   output logic            eng_en_o,
   output logic            cleanup_o,
   output logic            lengen_we_o,
   output logic [LG_W-1:0] lengen_data_o,
   output logic            irq_lost_o,
   output logic            dbg_o
);
   localparam int WD = (DISARM_CYCLES > 1) ? $clog2(DISARM_CYCLES) : 1;
   localparam int WR = (RETRY_BUDGET > 0) ? $clog2(RETRY_BUDGET + 1) : 1;
   localparam int WP = (DBG_INTERVAL > 1) ? $clog2(DBG_INTERVAL) : 1;
   localparam logic [LG_W-1:0] LENGEN_VAL = LG_W'(ENTRIES) | (LG_W'(1) << GEN_CHK_BIT);

   if (DISARM_CYCLES < 1) begin : g_chk_disarm
      $error("DISARM_CYCLES must be at least 1");
   end
   if (RETRY_BUDGET < 1) begin : g_chk_retry
      $error("RETRY_BUDGET must be at least 1");
   end
   if (DBG_INTERVAL < 2) begin : g_chk_dbg
      $error("DBG_INTERVAL must be at least 2");
   end
   if (GEN_CHK_BIT >= LG_W || ENTRIES >= (1 << GEN_CHK_BIT)) begin : g_chk_lengen
      $error("length word cannot hold ENTRIES below the generation check bit");
   end

   seq_state_e st_q, st_d;
   logic       quiet, dl_zero, rt_zero, lost_q, waiting;

   assign quiet   = engine_quiet(drain_busy_i, abort_busy_i, int_en_i, sb_empty_i);
   assign waiting = (st_q == S_DISARM) || (st_q == S_POLL);

   always_comb begin
      st_d = st_q;
      if (shutdown_i) begin
         st_d = S_PARK;
      end else begin
         case (st_q)
            S_IDLE:   if (abort_req_i) st_d = S_DISARM;
            S_DISARM: if (disabled_irq_i || dl_zero) st_d = S_POLL;
            S_POLL:   if (quiet || rt_zero) st_d = S_CLEAN;
            S_CLEAN:  st_d = (link_active_i && running_i) ? S_REST0 : S_PARK;
            S_PARK:   if (link_evt_i && running_i) st_d = S_REST0;
            S_REST0:  st_d = S_REST1;
            S_REST1:  st_d = S_IDLE;
            default:  st_d = S_PARK;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= S_PARK;
         lost_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_d == S_REST0)
            lost_q <= 1'b0;
         else if (st_q == S_DISARM && !shutdown_i && !disabled_irq_i && dl_zero)
            lost_q <= 1'b1;
      end
   end

   seq_countdown #(.W(WD)) u_deadline (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (st_q == S_IDLE),
      .load_val_i (WD'(DISARM_CYCLES - 1)),
      .dec_i      (st_q == S_DISARM),
      .zero_o     (dl_zero)
   );

   seq_countdown #(.W(WR)) u_retry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (st_q != S_POLL),
      .load_val_i (WR'(RETRY_BUDGET)),
      .dec_i      ((st_q == S_POLL) && !quiet),
      .zero_o     (rt_zero)
   );

   seq_pacer #(.PERIOD(DBG_INTERVAL), .W(WP)) u_pacer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (st_d != st_q),
      .en_i   (waiting),
      .fire_o (dbg_o)
   );

   assign state_o       = status_of(st_q);
   assign eng_en_o      = (st_q == S_IDLE) || waiting || (st_q == S_REST1);
   assign cleanup_o     = (st_q == S_CLEAN);
   assign lengen_we_o   = (st_q == S_CLEAN);
   assign lengen_data_o = LENGEN_VAL;
   assign irq_lost_o    = lost_q;

   // R2: disarm is entered only from running idle on a request
   a_r2_disarm_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(state_o == AST_DISARMED) |-> ($past(st_q) == S_IDLE && $past(abort_req_i)));
   // R3: the lost flag rises only on a deadline without the indication
   a_r3_lost_on_deadline: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_lost_o) |-> $past(st_q == S_DISARM && !disabled_irq_i));
   // R5: cleanup follows polling
   a_r5_clean_after_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cleanup_o |-> $past(st_q) == S_POLL);
   // R6: one cleanup cycle, enable low during it
   a_r6_single_cleanup: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cleanup_o |=> !cleanup_o);
   a_r6_enable_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cleanup_o |-> !eng_en_o);
   // R8: the enable rises only after a low restart cycle
   a_r8_enable_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(eng_en_o) |-> $past(st_q) == S_REST0);
   a_r8_restart_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(st_q == S_REST0) |-> $past(running_i && !shutdown_i));
   // R9: shutdown parks the sequencer
   a_r9_shutdown_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shutdown_i |=> (st_q == S_PARK && !eng_en_o));
endmodule

// File: tb/tb_abort_restart_seq.sv
`timescale 1ns/1ps
module tb_abort_restart_seq;
   localparam int D   = 6;
   localparam int B   = 9;
   localparam int I   = 4;
   localparam int ENT = 256;
   localparam int LGW = 32;
   localparam int GCB = 18;

   logic clk = 1'b0, rst_n = 1'b0;
   logic abort_req = 0, disabled_irq = 0, drain_busy = 0, abort_busy = 0, int_en = 0;
   logic sb_empty = 1, link_active = 0, link_evt = 0, running = 1, shutdown = 0;
   logic [1:0] state_o;
   logic eng_en_o, cleanup_o, lengen_we_o, irq_lost_o, dbg_o;
   logic [LGW-1:0] lengen_data_o;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   abort_restart_seq #(.ENTRIES(ENT), .LG_W(LGW), .GEN_CHK_BIT(GCB),
      .DISARM_CYCLES(D), .RETRY_BUDGET(B), .DBG_INTERVAL(I)) dut (
      .clk_i(clk), .rst_ni(rst_n), .abort_req_i(abort_req), .disabled_irq_i(disabled_irq),
      .drain_busy_i(drain_busy), .abort_busy_i(abort_busy), .int_en_i(int_en),
      .sb_empty_i(sb_empty), .link_active_i(link_active), .link_evt_i(link_evt),
      .running_i(running), .shutdown_i(shutdown), .state_o(state_o), .eng_en_o(eng_en_o),
      .cleanup_o(cleanup_o), .lengen_we_o(lengen_we_o), .lengen_data_o(lengen_data_o),
      .irq_lost_o(irq_lost_o), .dbg_o(dbg_o));

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   function automatic int exp_dis(input int w);
      return (w < D) ? w + 1 : D;
   endfunction
   function automatic int exp_lost(input int w);
      return (w >= D) ? 1 : 0;
   endfunction
   function automatic int exp_poll(input int q);
      return ((q < B) ? q : B) + 1;
   endfunction
   function automatic longint exp_lengen();
      return longint'(ENT) | (longint'(1) << GCB);
   endfunction

   // pattern 0..3 picks the single condition that breaks quiet (R4)
   task automatic set_status(input bit q, input int pat);
      drain_busy = !q && (pat == 0);
      abort_busy = !q && (pat == 1);
      int_en     = !q && (pat == 2);
      sb_empty   = q || (pat != 3);
   endtask

   task automatic bring_up();
      link_evt = 1; @(negedge clk); link_evt = 0;
      chk("R8 restart low cycle state", state_o, 0);
      chk("R8 restart low cycle enable", eng_en_o, 0);
      chk("R8 lost flag cleared", irq_lost_o, 0);
      @(negedge clk);
      chk("R8 enable rises", eng_en_o, 1);
      @(negedge clk);
      chk("R8 running state", state_o, 0);
      chk("R8 running enable", eng_en_o, 1);
   endtask

   task automatic run_trial(input int w, input int q, input bit la, input int pat);
      int dlen = 0, plen = 0, dbgc = 0, guard = 0;
      link_active = la; set_status(0, pat);
      abort_req = 1; @(negedge clk); abort_req = 0;
      chk("R2 disarmed", state_o, 1);
      chk("R2 enable held", eng_en_o, 1);
      while (state_o == 2'd1 && guard < 200) begin
         if (dbg_o) dbgc++;
         disabled_irq = (dlen == w);
         dlen++; guard++;
         @(negedge clk);
      end
      disabled_irq = 0;
      chk("R3 disarm length", dlen, exp_dis(w));
      while (state_o == 2'd2 && !cleanup_o && guard < 200) begin
         if (dbg_o) dbgc++;
         set_status(plen >= q, pat);
         plen++; guard++;
         @(negedge clk);
      end
      chk("R5 R4 poll length", plen, exp_poll(q));
      chk("R10 debug pulses", dbgc, exp_dis(w) / I + exp_poll(q) / I);
      chk("R6 cleanup", cleanup_o, 1);
      chk("R6 lengen write", lengen_we_o, 1);
      chk("R6 lengen data", lengen_data_o, exp_lengen());
      chk("R6 enable low", eng_en_o, 0);
      chk("R3 lost flag", irq_lost_o, exp_lost(w));
      set_status(0, pat);
      @(negedge clk);
      if (la) begin
         chk("R7 immediate restart state", state_o, 0);
         chk("R7 immediate restart enable", eng_en_o, 0);
         chk("R8 lost cleared", irq_lost_o, 0);
         @(negedge clk);
         chk("R8 enable rises", eng_en_o, 1);
         @(negedge clk);
         chk("R7 running", state_o, 0);
      end else begin
         chk("R7 parked state", state_o, 2);
         chk("R7 parked enable", eng_en_o, 0);
         @(negedge clk);
         chk("R7 still parked", state_o, 2);
         chk("R6 no second cleanup", cleanup_o, 0);
         bring_up();
      end
      link_active = 0;
   endtask

   initial begin
      #(8 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      void'($urandom(32'h00c0ffee));
      repeat (3) @(negedge clk);
      chk("R1 reset state", state_o, 2);
      chk("R1 reset enable", eng_en_o, 0);
      chk("R1 reset cleanup", cleanup_o, 0);
      chk("R1 reset lengen write", lengen_we_o, 0);
      chk("R1 reset lost", irq_lost_o, 0);
      chk("R1 reset debug", dbg_o, 0);
      rst_n = 1; @(negedge clk);
      chk("R1 after reset state", state_o, 2);
      chk("R1 after reset enable", eng_en_o, 0);

      abort_req = 1; @(negedge clk); abort_req = 0;
      chk("R2 abort ignored when parked", state_o, 2);
      @(negedge clk);
      chk("R2 abort ignored enable", eng_en_o, 0);

      running = 0; link_evt = 1; @(negedge clk); link_evt = 0;
      chk("R8 refused without running", state_o, 2);
      chk("R8 refused enable", eng_en_o, 0);
      running = 1; shutdown = 1; link_evt = 1; @(negedge clk); link_evt = 0;
      chk("R9 refused under shutdown", state_o, 2);
      chk("R9 enable stays low", eng_en_o, 0);
      shutdown = 0;
      bring_up();

      run_trial(D - 1, 0, 1, 0);      // indication meets deadline
      run_trial(D + 2, B + 3, 0, 3);  // deadline and budget run out, sb_empty low
      run_trial(0, 2, 1, 1);
      run_trial(2, B, 1, 2);          // quiet in the budget's last cycle

      // R9: shutdown while polling
      abort_req = 1; @(negedge clk); abort_req = 0;
      disabled_irq = 1; @(negedge clk); disabled_irq = 0;
      chk("R2 polling enable", eng_en_o, 1);
      chk("R9 polling before shutdown", state_o, 2);
      set_status(0, 0); shutdown = 1; @(negedge clk);
      chk("R9 parked", state_o, 2);
      chk("R9 no cleanup", cleanup_o, 0);
      chk("R9 enable low", eng_en_o, 0);
      link_evt = 1; @(negedge clk); link_evt = 0;
      chk("R9 link event ignored", state_o, 2);
      chk("R9 link event enable", eng_en_o, 0);
      shutdown = 0; @(negedge clk);
      chk("R9 no late cleanup", cleanup_o, 0);
      bring_up();

      for (int t = 0; t < 40; t++) begin
         run_trial(int'($urandom_range(0, D + 2)), int'($urandom_range(0, B + 3)),
                   bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
      end
      summary();
   end
endmodule